// File: doc/BRIEF.md
# Register-Programmable Even Clock Divider

This block derives a slower clock from its input clock. The division factor is always even and is set by one 32-bit control word. Software reads and writes that word through a small synchronous port made of an address-match strobe, a write strobe, write data and read data. The output is a registered level with a 50% duty cycle. A single enable bit gates it, and the block needs no software action after reset: it wakes up enabled at divide-by-8.

The waveform comes from a three-state machine with a half-period counter. The states are `GEN_IDLE` (output parked low), `GEN_HIGH` and `GEN_LOW`. The transitions are:
- *start*: `GEN_IDLE`→`GEN_HIGH`, taken while enabled.
- *fall*: `GEN_HIGH`→`GEN_LOW`, taken at the terminal count.
- *rise*: `GEN_LOW`→`GEN_HIGH`, taken at the terminal count while enabled.
- *park*: `GEN_LOW`→`GEN_IDLE`, taken at the terminal count while disabled.

The half-period length is latched only on *start* and *rise*, which are the rising edges of the output. A ratio write therefore never shortens or stretches a level that is already under way. Gating only parks the output after a complete low level.

Top module: `even_clk_div`

## Requirements
- R1: While `reg_sel` is high, `reg_rdata` shows the stored word in the same cycle: bit 15 is the enable bit, bits 4:0 are the ratio code, and all other bits are 0. While `reg_sel` is low, `reg_rdata` is all zeros.
- R2: Bits 31:16 and 14:5 of a written word are discarded. They always read back as 0.
- R3: The register updates on a clock edge only when `reg_sel` and `reg_wr` are both high. A write strobe without the address match leaves the register unchanged.
- R4: While `rst` is high, `clk_out` is low. After reset the register reads 0x0000_8003. `clk_out` goes high at the first edge after `rst` is released and then runs at ÷8: 4 cycles high and 4 cycles low.
- R5: For a ratio code c from 0 to 7, each output level lasts c+1 input cycles, so the output period is 2(c+1) cycles.
- R6: Ratio codes 8 to 31 make the output run as code 7 (÷16). The register still reads back the code that was written.
- R7: A new ratio code is adopted only at the next rising edge of `clk_out`. The high and low levels in progress keep their old widths.
- R8: When the enable bit is 0, `clk_out` first completes its current high and low levels and then stays low.
- R9: When the enable bit is written as 1 while the output is parked, `clk_out` rises at the second clock edge, counting the write edge as the first. Its first high level has the full width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | Address match for the control word |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational |
| clk_out | output | 1 | Divided, gated output clock |

## Verification
The bench builds the block with its default parameters:
- the enable bit at position 15;
- a 5-bit ratio field;
- a highest legal code of 7;
- a reset code of 3 with the enable bit set.

These defaults make every legal half-period from 1 to 8 cycles reachable. The same field width also spans the reserved codes 8 to 31, so the clamp to ÷16 can be exercised. A half-period of 1 cycle exercises the counter at the point where it expires on the cycle it is loaded. Switching from ÷16 to ÷2 in the middle of a high level shows that the widest and the narrowest settings hand over cleanly.

// File: rtl/even_div_pkg.sv
package even_div_pkg;

    // Output generator states
    typedef enum logic [1:0] {
        GEN_IDLE = 2'd0,
        GEN_HIGH = 2'd1,
        GEN_LOW  = 2'd2
    } gen_state_e;

endpackage

// File: rtl/div_ctrl_reg.sv
module div_ctrl_reg #(
    parameter int DATA_W    = 32,
    parameter int EN_POS    = 15,
    parameter int RATIO_W   = 5,
    parameter bit RST_EN    = 1'b1,
    parameter int RST_RATIO = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sel,
    input  logic               wr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic               en_q,
    output logic [RATIO_W-1:0] ratio_q
);

    logic              wr_hit;
    logic [DATA_W-1:0] rd_word;

    assign wr_hit = sel && wr;

    // Only the implemented fields are stored; reserved bits have no flops.
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= RST_EN;
            ratio_q <= RATIO_W'(RST_RATIO);
        end else if (wr_hit) begin
            en_q    <= wdata[EN_POS];
            ratio_q <= wdata[RATIO_W-1:0];
        end
    end

    always_comb begin
        rd_word                = '0;
        rd_word[EN_POS]        = en_q;
        rd_word[RATIO_W-1:0]   = ratio_q;
        rdata                  = sel ? rd_word : '0;
    end

endmodule

// File: rtl/div_ratio_dec.sv
module div_ratio_dec #(
    parameter int RATIO_W  = 5,
    parameter int MAX_CODE = 7,
    parameter int HALF_W   = 4
) (
    input  logic [RATIO_W-1:0] code,
    output logic [HALF_W-1:0]  half
);

    logic               legal;
    logic [RATIO_W-1:0] eff_code;

    // Reserved codes clamp to the slowest legal setting.
    always_comb begin
        legal    = (code <= RATIO_W'(MAX_CODE));
        eff_code = legal ? code : RATIO_W'(MAX_CODE);
        half     = HALF_W'(eff_code) + HALF_W'(1);
    end

endmodule

// File: rtl/div_gen_fsm.sv
module div_gen_fsm
    import even_div_pkg::*;
#(
    parameter int HALF_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [HALF_W-1:0] half_in,
    output logic              clk_out,
    output logic [HALF_W-1:0] act_half
);

    gen_state_e        state_q, state_d;
    logic [HALF_W-1:0] cnt_q, cnt_d;
    logic [HALF_W-1:0] half_d;
    logic              term;
    logic              out_q;

    assign term = (cnt_q == act_half - HALF_W'(1));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        half_d  = act_half;
        unique case (state_q)
            GEN_IDLE: begin
                if (en) begin                 // start
                    state_d = GEN_HIGH;
                    cnt_d   = '0;
                    half_d  = half_in;
                end
            end
            GEN_HIGH: begin
                if (term) begin               // fall
                    state_d = GEN_LOW;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + HALF_W'(1);
                end
            end
            GEN_LOW: begin
                if (term) begin
                    cnt_d = '0;
                    if (en) begin             // rise
                        state_d = GEN_HIGH;
                        half_d  = half_in;
                    end else begin            // park
                        state_d = GEN_IDLE;
                    end
                end else begin
                    cnt_d = cnt_q + HALF_W'(1);
                end
            end
            default: begin
                state_d = GEN_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= GEN_IDLE;
            cnt_q    <= '0;
            act_half <= HALF_W'(1);
        end else begin
            state_q  <= state_d;
            cnt_q    <= cnt_d;
            act_half <= half_d;
        end
    end

    // Registered output level
    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= 1'b0;
        end else begin
            out_q <= (state_d == GEN_HIGH);
        end
    end

    assign clk_out = out_q;

endmodule

// File: rtl/even_clk_div.sv
module even_clk_div #(
    parameter int DATA_W    = 32,
    parameter int EN_POS    = 15,
    parameter int RATIO_W   = 5,
    parameter int MAX_CODE  = 7,
    parameter bit RST_EN    = 1'b1,
    parameter int RST_RATIO = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              clk_out
);

    localparam int HALF_W = $clog2(MAX_CODE + 2);

    logic               ctrl_en;
    logic [RATIO_W-1:0] ctrl_ratio;
    logic [HALF_W-1:0]  dec_half;
    logic [HALF_W-1:0]  act_half;

    div_ctrl_reg #(
        .DATA_W   (DATA_W),
        .EN_POS   (EN_POS),
        .RATIO_W  (RATIO_W),
        .RST_EN   (RST_EN),
        .RST_RATIO(RST_RATIO)
    ) u_reg (
        .clk    (clk),
        .rst    (rst),
        .sel    (reg_sel),
        .wr     (reg_wr),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .en_q   (ctrl_en),
        .ratio_q(ctrl_ratio)
    );

    div_ratio_dec #(
        .RATIO_W (RATIO_W),
        .MAX_CODE(MAX_CODE),
        .HALF_W  (HALF_W)
    ) u_dec (
        .code(ctrl_ratio),
        .half(dec_half)
    );

    div_gen_fsm #(
        .HALF_W(HALF_W)
    ) u_gen (
        .clk     (clk),
        .rst     (rst),
        .en      (ctrl_en),
        .half_in (dec_half),
        .clk_out (clk_out),
        .act_half(act_half)
    );

endmodule

// File: rtl/even_clk_div_chk.sv
module even_clk_div_chk #(
    parameter int DATA_W   = 32,
    parameter int EN_POS   = 15,
    parameter int RATIO_W  = 5,
    parameter int MAX_CODE = 7,
    parameter int HALF_W   = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               reg_sel,
    input logic               reg_wr,
    input logic [DATA_W-1:0]  reg_wdata,
    input logic [DATA_W-1:0]  reg_rdata,
    input logic               clk_out,
    input logic               ctrl_en,
    input logic [RATIO_W-1:0] ctrl_ratio,
    input logic [HALF_W-1:0]  act_half
);

    localparam logic [DATA_W-1:0] LIVE_MASK =
        (DATA_W'(1) << EN_POS) | ((DATA_W'(1) << RATIO_W) - DATA_W'(1));

    // R1
    no_sel_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !reg_sel |-> (reg_rdata == '0));

    // R2
    rsv_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        reg_sel |-> ((reg_rdata & ~LIVE_MASK) == '0));

    // R3
    wr_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_sel && reg_wr) |=> (ctrl_ratio == $past(reg_wdata[RATIO_W-1:0])));

    // R3
    no_wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(reg_sel && reg_wr) |=> $stable(ctrl_ratio) && $stable(ctrl_en));

    // R6
    half_range_chk: assert property (@(posedge clk) disable iff (rst)
        (act_half >= HALF_W'(1)) && (act_half <= HALF_W'(MAX_CODE + 1)));

    // R7
    ratio_adopt_chk: assert property (@(posedge clk) disable iff (rst)
        !$rose(clk_out) |-> $stable(act_half));

    // R8
    rise_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_out) |-> $past(ctrl_en));

endmodule

bind even_clk_div even_clk_div_chk #(
    .DATA_W  (DATA_W),
    .EN_POS  (EN_POS),
    .RATIO_W (RATIO_W),
    .MAX_CODE(MAX_CODE),
    .HALF_W  (HALF_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_sel   (reg_sel),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .clk_out   (clk_out),
    .ctrl_en   (ctrl_en),
    .ctrl_ratio(ctrl_ratio),
    .act_half  (act_half)
);

// File: tb/even_clk_div_tb.sv
module even_clk_div_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 8;
    localparam int GUARD      = 1000;

    // Vector table: written word, expected read-back, expected level width
    localparam logic [31:0] VEC_WR [NVEC] = '{
        32'h0000_8000, 32'hFFFF_8001, 32'h0000_8002, 32'h0000_8004,
        32'h0000_8007, 32'h0000_801F, 32'h7FE0_800A, 32'h0000_FFE5
    };
    localparam logic [31:0] VEC_RD [NVEC] = '{
        32'h0000_8000, 32'h0000_8001, 32'h0000_8002, 32'h0000_8004,
        32'h0000_8007, 32'h0000_801F, 32'h0000_800A, 32'h0000_8005
    };
    localparam int VEC_HALF [NVEC] = '{1, 2, 3, 5, 8, 8, 8, 6};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_sel = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        clk_out;

    int checks = 0;
    int fails  = 0;

    even_clk_div u_dut (
        .clk      (clk),
        .rst      (rst),
        .reg_sel  (reg_sel),
        .reg_wr   (reg_wr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .clk_out  (clk_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [31:0] w);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = w;
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic reg_read(output logic [31:0] v);
        @(negedge clk);
        reg_sel = 1'b1;
        #1 v = reg_rdata;
        reg_sel = 1'b0;
    endtask

    task automatic count_level(input logic lvl, output int n);
        n = 0;
        while (clk_out === lvl && n < GUARD) begin
            n++;
            @(negedge clk);
        end
    endtask

    // Sync to a rising edge after a low level, then measure one period.
    task automatic measure(output int hi, output int lo);
        int g;
        g = 0;
        @(negedge clk);
        while (clk_out !== 1'b0 && g < GUARD) begin g++; @(negedge clk); end
        while (clk_out !== 1'b1 && g < GUARD) begin g++; @(negedge clk); end
        count_level(1'b1, hi);
        count_level(1'b0, lo);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] rv;
        int hi, lo, n;

        // Reset state (R4)
        repeat (3) @(negedge clk);
        chk("R4 out low in reset", {31'b0, clk_out}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk("R4 first rise after reset", {31'b0, clk_out}, 32'h1);
        reg_read(rv);
        chk("R4 reset readback", rv, 32'h0000_8003);
        measure(hi, lo);
        chk("R4 reset high width", hi, 4);
        chk("R4 reset low width", lo, 4);

        // Vector walk (R1 R2 R5 R6)
        for (int i = 0; i < NVEC; i++) begin
            reg_write(VEC_WR[i]);
            reg_read(rv);
            chk("R1 R2 R6 readback", rv, VEC_RD[i]);
            measure(hi, lo);
            chk("R5 R6 high width", hi, VEC_HALF[i]);
            chk("R5 R6 low width", lo, VEC_HALF[i]);
        end

        // No read without address match (R1)
        @(negedge clk);
        chk("R1 rdata zero without sel", reg_rdata, 32'h0);

        // Write strobe without address match is ignored (R3)
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b1; reg_wdata = 32'h0000_0000;
        @(negedge clk);
        reg_wr = 1'b0;
        reg_read(rv);
        chk("R3 unselected write ignored", rv, 32'h0000_8005);
        measure(hi, lo);
        chk("R3 ratio kept", hi, 6);

        // Ratio change mid-high (R7)
        reg_write(32'h0000_8007);
        measure(hi, lo);
        n = 0;
        @(negedge clk);
        while (clk_out !== 1'b0 && n < GUARD) begin n++; @(negedge clk); end
        while (clk_out !== 1'b1 && n < GUARD) begin n++; @(negedge clk); end
        reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = 32'h0000_8000;
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
        count_level(1'b1, hi);
        chk("R7 current high kept", hi + 1, 8);
        count_level(1'b0, lo);
        chk("R7 current low kept", lo, 8);
        count_level(1'b1, hi);
        chk("R7 new ratio high", hi, 1);
        count_level(1'b0, lo);
        chk("R7 new ratio low", lo, 1);

        // Disable parks low (R8)
        reg_write(32'h0000_8003);
        measure(hi, lo);
        reg_write(32'h0000_0003);
        reg_read(rv);
        chk("R8 disabled readback", rv, 32'h0000_0003);
        repeat (20) @(negedge clk);
        n = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (clk_out === 1'b1) n++;
        end
        chk("R8 output parked low", n, 0);

        // Re-enable: full first pulse (R9)
        reg_write(32'h0000_8003);
        chk("R9 low at write edge", {31'b0, clk_out}, 32'h0);
        @(negedge clk);
        chk("R9 rise on second edge", {31'b0, clk_out}, 32'h1);
        count_level(1'b1, hi);
        chk("R9 first high full width", hi, 4);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule